// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block sits next to a small 8-bit CPU core with a 16-bit address bus and decides when the core must leave normal program flow for a background debug routine. Software loads a break address into two byte registers and sets an enable bit. The block then watches opcode fetches. When a fetched address equals the stored one, or when software writes 1 to the break flag, a break becomes pending.

A pending break waits for the core to finish its current instruction. At that boundary the block tells the core to take a software-interrupt opcode, and the break becomes active. The block also supplies the vector address the core must use. This address moves down by 256 bytes in monitor mode. While the break is active, the watchdog is held off. A clear-enable bit decides whether status flags elsewhere in the chip may be cleared. A return-from-interrupt seen during the break, or a software write of 0 to the break flag, ends the break.

Top module: `brk_ctrl`

## Requirements
- R1: After reset the address bytes, the enable bit, the clear-enable bit and the break flag all read 0. `brk_active_o`, `cop_hold_o` and `swi_o` are 0, and `flag_clr_ok_o` is 1.
- R2: Register offset 0 holds the high byte of the break address and offset 1 holds the low byte. At offset 2, bit 7 is the match enable and bit 6 is the break flag. At offset 3, bit 7 is the clear-enable. `reg_rdata_o` shows the register at `reg_addr_i` in the same cycle, with unused bits reading 0.
- R3: When the core is idle, enable is 1, `opfetch_i` is 1 and `cpu_addr_i` equals the break address, the break becomes pending at the clock edge. From the next cycle the break flag reads 1.
- R4: An access with `opfetch_i`=0, or any fetch while enable is 0, never makes a break pending.
- R5: Writing offset 2 with bit 6 = 1 while idle makes a break pending, whatever the enable bit is.
- R6: While a break is pending, `insn_done_i`=1 drives `swi_o` high in that same cycle, and `brk_active_o` rises at the next cycle.
- R7: `rti_i`=1 while active returns the block to idle at the next cycle. The break flag then reads 0. `rti_i` has no effect while pending or idle.
- R8: Writing offset 2 with bit 6 = 0 returns the block to idle at the next cycle, whatever its state. In that cycle `swi_o` stays 0, and this write wins over a simultaneous match or `insn_done_i`.
- R9: `vec_addr_o` is 16'hFFFC when `monitor_i`=0 and 16'hFEFC when `monitor_i`=1.
- R10: `cop_hold_o` is 1 exactly while the break is active.
- R11: `flag_clr_ok_o` is 0 only while the break is active with clear-enable = 0.
- R12: A match while a break is pending or active is ignored. No second `swi_o` pulse occurs and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| cpu_addr_i | input | 16 | CPU address bus |
| opfetch_i | input | 1 | Current cycle is an opcode fetch |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| rti_i | input | 1 | Return-from-interrupt executes this cycle |
| monitor_i | input | 1 | Monitor mode active |
| swi_o | output | 1 | Take software-interrupt opcode now |
| brk_active_o | output | 1 | Break state active |
| vec_addr_o | output | 16 | Address of break vector high byte |
| cop_hold_o | output | 1 | Hold off the watchdog |
| flag_clr_ok_o | output | 1 | Status flags may be cleared |

## Verification
Register reads, `vec_addr_o`, `flag_clr_ok_o` and `swi_o` respond in the same cycle. The bench therefore drives the inputs on the falling edge and checks these outputs one time unit later, before the next rising edge. Changes of state caused by a match, a software write, `insn_done_i` or `rti_i` appear one rising edge later. The bench model updates its state only at that edge, so the flag and `brk_active_o` are compared on the following falling-edge step. Directed steps cover write-versus-event collisions and nested matches, and random steps with biased address choice cover the rest.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2
  } brk_state_e;
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RAW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           flag_i,
  output logic [DW-1:0]  rdata_o,
  output logic [AW-1:0]  brk_addr_o,
  output logic           en_o,
  output logic           bcfe_o,
  output logic           sw_set_o,
  output logic           sw_clr_o
);
  localparam int NB = AW / DW;
  localparam logic [RAW-1:0] CTRL_OFS = RAW'(NB);
  localparam logic [RAW-1:0] FCTL_OFS = RAW'(NB + 1);

  logic [AW-1:0] addr_q;
  logic          en_q, bcfe_q;

  // offset 0 is the most significant byte
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  addr_q[b*DW +: DW] <= '0;
      else if (we_i && addr_i == RAW'(NB - 1 - b)) addr_q[b*DW +: DW] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      bcfe_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == CTRL_OFS) en_q   <= wdata_i[DW-1];
      if (addr_i == FCTL_OFS) bcfe_q <= wdata_i[DW-1];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++)
      if (addr_i == RAW'(i)) rdata_o = addr_q[(NB-1-i)*DW +: DW];
    if (addr_i == CTRL_OFS) begin
      rdata_o[DW-1] = en_q;
      rdata_o[DW-2] = flag_i;
    end
    if (addr_i == FCTL_OFS) rdata_o[DW-1] = bcfe_q;
  end

  assign sw_set_o   = we_i && addr_i == CTRL_OFS &&  wdata_i[DW-2];
  assign sw_clr_o   = we_i && addr_i == CTRL_OFS && !wdata_i[DW-2];
  assign brk_addr_o = addr_q;
  assign en_o       = en_q;
  assign bcfe_o     = bcfe_q;

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(addr_q));
endmodule

// File: rtl/brk_match.sv
module brk_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [AW-1:0] brk_addr_i,
  input  logic          opfetch_i,
  input  logic          en_i,
  output logic          hit_o
);
  assign hit_o = en_i && opfetch_i && (cpu_addr_i == brk_addr_i);
endmodule

// File: rtl/brk_fsm.sv
module brk_fsm
  import brk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic insn_done_i,
  input  logic rti_i,
  output logic swi_o,
  output logic pend_o,
  output logic active_o
);
  brk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (sw_clr_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE: if (hit_i || sw_set_i) st_d = ST_PEND;
        ST_PEND: if (insn_done_i)       st_d = ST_ACT;
        ST_ACT:  if (rti_i)             st_d = ST_IDLE;
        default:                        st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign swi_o    = (st_q == ST_PEND) && insn_done_i && !sw_clr_i;
  assign pend_o   = (st_q == ST_PEND);
  assign active_o = (st_q == ST_ACT);

  p_match_pend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && hit_i && !sw_clr_i) |=> pend_o);
  p_enter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(swi_o));
  p_rti_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && rti_i) |=> !active_o && !pend_o);
  p_sw_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_i |=> !active_o && !pend_o);
  p_no_nest_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !swi_o);
  p_state_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pend_o, active_o}));
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl #(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter logic [15:0] NRM_VEC = 16'hFFFC,
  parameter logic [15:0] MON_VEC = 16'hFEFC
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_we_i,
  input  logic [$clog2(AW/DW+2)-1:0]   reg_addr_i,
  input  logic [DW-1:0]                reg_wdata_i,
  output logic [DW-1:0]                reg_rdata_o,
  input  logic [AW-1:0]                cpu_addr_i,
  input  logic                         opfetch_i,
  input  logic                         insn_done_i,
  input  logic                         rti_i,
  input  logic                         monitor_i,
  output logic                         swi_o,
  output logic                         brk_active_o,
  output logic [AW-1:0]                vec_addr_o,
  output logic                         cop_hold_o,
  output logic                         flag_clr_ok_o
);
  localparam int RAW = $clog2(AW / DW + 2);

  logic [AW-1:0] brk_addr;
  logic en, bcfe, sw_set, sw_clr, hit, pend, active;

  brk_regs #(.AW(AW), .DW(DW), .RAW(RAW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_i(pend || active), .rdata_o(reg_rdata_o),
    .brk_addr_o(brk_addr), .en_o(en), .bcfe_o(bcfe),
    .sw_set_o(sw_set), .sw_clr_o(sw_clr)
  );

  brk_match #(.AW(AW)) u_match (
    .cpu_addr_i, .brk_addr_i(brk_addr), .opfetch_i, .en_i(en), .hit_o(hit)
  );

  brk_fsm u_fsm (
    .clk_i, .rst_ni, .hit_i(hit), .sw_set_i(sw_set), .sw_clr_i(sw_clr),
    .insn_done_i, .rti_i, .swi_o, .pend_o(pend), .active_o(active)
  );

  assign brk_active_o  = active;
  assign cop_hold_o    = active;
  assign vec_addr_o    = monitor_i ? AW'(MON_VEC) : AW'(NRM_VEC);
  assign flag_clr_ok_o = !active || bcfe;

  p_data_nohit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend && !active && !opfetch_i && !reg_we_i) |=> !pend);
  p_flag_guard_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_clr_ok_o |-> cop_hold_o);
endmodule

// File: tb/brk_ctrl_bench.sv
module brk_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  ra = '0;
  logic [7:0]  wd = '0;
  logic [15:0] ca = '0;
  logic        of = 1'b0, id = 1'b0, rti = 1'b0, mon = 1'b0;
  logic [7:0]  rd;
  logic        swi, act, cop, clr_ok;
  logic [15:0] vec;

  int checks = 0, fails = 0;
  bit done = 0;

  // model: 0 idle, 1 pending, 2 active
  int          m_st = 0;
  logic [15:0] m_addr = '0;
  logic        m_en = 0, m_bcfe = 0;

  always #2 clk = ~clk;

  brk_ctrl u_brk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .cpu_addr_i(ca), .opfetch_i(of),
    .insn_done_i(id), .rti_i(rti), .monitor_i(mon), .swi_o(swi),
    .brk_active_o(act), .vec_addr_o(vec), .cop_hold_o(cop),
    .flag_clr_ok_o(clr_ok)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] a, input logic [15:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] r);
    case (r)
      2'd0:    return m_addr[15:8];
      2'd1:    return m_addr[7:0];
      2'd2:    return {m_en, m_st != 0, 6'b0};
      default: return {m_bcfe, 7'b0};
    endcase
  endfunction

  task automatic step(input logic w, input logic [1:0] r, input logic [7:0] d,
                      input logic [15:0] a, input logic f, input logic i,
                      input logic t, input logic m, input string tag);
    logic clr, set, hit, eswi;
    we = w; ra = r; wd = d; ca = a; of = f; id = i; rti = t; mon = m;
    #1;
    clr  = w && r == 2'd2 && !d[6];
    set  = w && r == 2'd2 && d[6];
    hit  = f && m_en && a == m_addr;
    eswi = m_st == 1 && i && !clr;
    chk(tag, "rdata", 16'(rd), 16'(exp_rd(r)));
    chk(tag, "swi", 16'(swi), 16'(eswi));
    chk(tag, "active", 16'(act), 16'(m_st == 2));
    chk(tag, "cop", 16'(cop), 16'(m_st == 2));
    chk(tag, "clr_ok", 16'(clr_ok), 16'(m_st != 2 || m_bcfe));
    chk(tag, "vec", vec, m ? 16'hFEFC : 16'hFFFC);
    @(posedge clk);
    if (clr) m_st = 0;
    else if (m_st == 0 && (hit || set)) m_st = 1;
    else if (m_st == 1 && i) m_st = 2;
    else if (m_st == 2 && t) m_st = 0;
    if (w) case (r)
      2'd0: m_addr[15:8] = d;
      2'd1: m_addr[7:0]  = d;
      2'd2: m_en   = d[7];
      default: m_bcfe = d[7];
    endcase
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [1:0] r, input string tag);
    step(0, r, 8'h00, 16'h0000, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #80000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int k = 0; k < 4; k++) rd_reg(2'(k), "R1");
    // R2 register access
    step(1, 2'd0, 8'h12, 16'h0, 0, 0, 0, 0, "R2");
    step(1, 2'd1, 8'h34, 16'h0, 0, 0, 0, 0, "R2");
    rd_reg(2'd0, "R2"); rd_reg(2'd1, "R2");
    // R4 disabled match, then data access
    step(0, 2'd2, 8'h0, 16'h1234, 1, 0, 0, 0, "R4");
    rd_reg(2'd2, "R4");
    step(1, 2'd2, 8'h80, 16'h0, 0, 0, 0, 0, "R2");
    step(0, 2'd2, 8'h0, 16'h1234, 0, 0, 0, 0, "R4");
    rd_reg(2'd2, "R4");
    // R3 fetch match
    step(0, 2'd2, 8'h0, 16'h1234, 1, 0, 0, 0, "R3");
    rd_reg(2'd2, "R3");
    // R12 match while pending, R6 entry, R12 match while active
    step(0, 2'd2, 8'h0, 16'h1234, 1, 0, 0, 0, "R12");
    step(0, 2'd2, 8'h0, 16'h1234, 1, 1, 0, 0, "R6");
    step(0, 2'd2, 8'h0, 16'h1234, 1, 1, 0, 0, "R12");
    rd_reg(2'd2, "R10");
    // R7 rti ignored while pending is covered below; R11 clear-enable
    step(1, 2'd3, 8'h80, 16'h0, 0, 0, 0, 0, "R11");
    rd_reg(2'd3, "R11");
    step(1, 2'd3, 8'h00, 16'h0, 0, 0, 0, 1, "R9");
    step(0, 2'd2, 8'h0, 16'h0, 0, 0, 1, 1, "R7");
    rd_reg(2'd2, "R7");
    // R5 software request with enable off
    step(1, 2'd2, 8'h40, 16'h1234, 0, 0, 0, 0, "R5");
    step(0, 2'd2, 8'h0, 16'h0, 0, 0, 1, 0, "R7");
    rd_reg(2'd2, "R5");
    step(0, 2'd2, 8'h0, 16'h0, 0, 1, 0, 0, "R6");
    // R8 clear wins over rti, and over insn_done while pending
    step(1, 2'd2, 8'h00, 16'h0, 0, 0, 1, 0, "R8");
    rd_reg(2'd2, "R8");
    step(1, 2'd2, 8'h40, 16'h0, 0, 0, 0, 0, "R5");
    step(1, 2'd2, 8'h80, 16'h1234, 1, 1, 0, 0, "R8");
    rd_reg(2'd2, "R8");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      a = ($urandom % 2) ? m_addr : 16'($urandom);
      step(($urandom % 10) == 0, 2'($urandom), 8'($urandom), a,
           ($urandom % 2) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0,
           ($urandom % 4) == 0, "RND");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule